// File: doc/BRIEF.md
# Quadrant-Folded Carrier Phase Error Lookup

This block produces a one-bit carrier phase error for a demodulator. Each cycle it takes a 12-bit two's complement I/Q symbol pair and shortens each component to its most significant bits, by rounding or by truncation. In folding mode it maps the pair into the first quadrant as a magnitude plus a sign. The shortened pair addresses a user-loaded table of 4096 one-bit entries. The table is stored as 256 words of 16 bits, and a 16-to-1 bit select picks one entry.

In folding mode the table only describes one quadrant. The looked-up sign is then corrected for the quadrant the sample came from. An output of 0 asks the loop to advance the phase and an output of 1 asks it to retard the phase. A host loads the table one word at a time. The table cannot be read back through the write port.

Top module: `phase_err_lut`

## Requirements
- R1: Table entry n (n = 64*Iidx + Qidx, each index 6 bits) is bit n[3:0] of word n[11:4]. A host write with wr_en high and wr_addr[8] = 1 stores wr_data into word wr_addr[7:0].
- R2: A host write with wr_addr[8] = 0 leaves the table unchanged.
- R3: With fold_en = 0 and rnd_en = 0, each index is the truncated top 6 bits of the sample (bits 11:6), used as a 6-bit two's complement code.
- R4: With fold_en = 1, each sample is shortened to its top 7 bits (bits 11:5). The index is the 6-bit magnitude, obtained by two's complement negation when the 7-bit value is negative. A value of -64 gives magnitude 63.
- R5: With fold_en = 1 and ones_neg = 1, negative values are negated by bit inversion instead of two's complement.
- R6: With rnd_en = 1, the shortening rounds to nearest. An exact half rounds up only when the kept value is odd.
- R7: Rounding that would carry the largest positive code past full scale leaves the largest positive code.
- R8: With fold_en = 1, the table bit is inverted when exactly one of the I and Q signs is negative. With fold_en = 0 it is never inverted.
- R9: err_out is 0 after reset. err_out shows the result for a sample two clock edges after that sample is presented.
- R10: A lookup presented after a host write completes uses the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the pipeline |
| i_in | input | 12 | In-phase sample, two's complement |
| q_in | input | 12 | Quadrature sample, two's complement |
| fold_en | input | 1 | Fold the pair into one quadrant |
| rnd_en | input | 1 | Round (1) or truncate (0) |
| ones_neg | input | 1 | Use bit inversion for negation in folding mode |
| wr_en | input | 1 | Host table write strobe |
| wr_addr | input | 9 | Host word address; the upper half selects the table |
| wr_data | input | 16 | Table word |
| err_out | output | 1 | Phase error sign: 0 advance, 1 retard |

## Verification
The bench builds the block with its default parameters: 12-bit samples, 6-bit indices and 16-bit words. With these values the extreme codes, -2048 and +2047, and the exact-half fractions of both shortening widths can all be driven directly. The table is filled with a computed pattern that the bench mirrors. Each lookup is then predicted from the index and the fold correction, and covers full-scale saturation, the -64 magnitude case and both negation styles.

// File: rtl/phase_err_lut.sv
module phase_err_lut #(
  parameter int SAMP_W = 12,
  parameter int IDX_W  = 6,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SAMP_W-1:0] i_in,
  input  logic [SAMP_W-1:0] q_in,
  input  logic              fold_en,
  input  logic              rnd_en,
  input  logic              ones_neg,
  input  logic              wr_en,
  input  logic [2*IDX_W-$clog2(WORD_W):0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic              err_out
);
  localparam int BSEL_W  = $clog2(WORD_W);
  localparam int WADDR_W = 2*IDX_W - BSEL_W;
  localparam int DEPTH   = 1 << WADDR_W;
  localparam int K_W     = IDX_W + 1;
  localparam int FR_W    = SAMP_W - IDX_W;

  function automatic logic [K_W-1:0] shorten(input logic [SAMP_W-1:0] s,
                                             input logic fold, input logic rnd);
    logic [K_W-1:0]  k, kmax;
    logic [FR_W-1:0] fr, half;
    logic            up;
    if (fold) begin
      k    = s[SAMP_W-1 -: K_W];
      fr   = {1'b0, s[FR_W-2:0]};
      half = FR_W'(1) << (FR_W-2);
      kmax = {1'b0, {IDX_W{1'b1}}};
    end else begin
      k    = {s[SAMP_W-1], s[SAMP_W-1 -: IDX_W]};
      fr   = s[FR_W-1:0];
      half = FR_W'(1) << (FR_W-1);
      kmax = {2'b00, {(IDX_W-1){1'b1}}};
    end
    up = rnd && ((fr > half) || ((fr == half) && k[0]));
    return (up && (k != kmax)) ? k + 1'b1 : k;
  endfunction

  function automatic logic [IDX_W-1:0] to_index(input logic [K_W-1:0] k,
                                                input logic fold, input logic inv);
    logic [K_W-1:0] m;
    m = ~k + 1'b1;
    if (!fold || !k[K_W-1]) return k[IDX_W-1:0];
    if (inv)                return ~k[IDX_W-1:0];
    return m[IDX_W] ? {IDX_W{1'b1}} : m[IDX_W-1:0];
  endfunction

  logic [K_W-1:0]     ri, rq;
  logic [IDX_W-1:0]   ii, qi;
  logic [WADDR_W-1:0] word_q;
  logic [BSEL_W-1:0]  bsel_q;
  logic               flip_q;
  logic [WORD_W-1:0]  mem [DEPTH];

  assign ri = shorten(i_in, fold_en, rnd_en);
  assign rq = shorten(q_in, fold_en, rnd_en);
  assign ii = to_index(ri, fold_en, ones_neg);
  assign qi = to_index(rq, fold_en, ones_neg);

  always_ff @(posedge clk)
    if (wr_en && wr_addr[WADDR_W])
      mem[wr_addr[WADDR_W-1:0]] <= wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q  <= '0;
      bsel_q  <= '0;
      flip_q  <= 1'b0;
      err_out <= 1'b0;
    end else begin
      word_q  <= {ii, qi[IDX_W-1 -: (IDX_W-BSEL_W)]};
      bsel_q  <= qi[BSEL_W-1:0];
      flip_q  <= fold_en && (ri[K_W-1] ^ rq[K_W-1]);
      err_out <= mem[word_q][bsel_q] ^ flip_q;
    end
  end

  logic [K_W-1:0] tr_i;
  assign tr_i = fold_en ? i_in[SAMP_W-1 -: K_W] : {i_in[SAMP_W-1], i_in[SAMP_W-1 -: IDX_W]};

  assert_round_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (K_W'(ri - tr_i) <= K_W'(1)));
  assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !i_in[SAMP_W-1] |-> !ri[K_W-1]);
  assert_no_flip_unfolded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fold_en |=> !flip_q);
  assert_word_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[WADDR_W]) |=> mem[$past(wr_addr[WADDR_W-1:0])] == $past(wr_data));
  assert_idle_after_reset_R9: assert property (@(posedge clk)
    !rst_n |=> !err_out);
endmodule

// File: tb/test_phase_err_lut.sv
module test_phase_err_lut;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] i_in = '0, q_in = '0;
  logic fold_en = 0, rnd_en = 0, ones_neg = 0, wr_en = 0;
  logic [8:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic err_out;
  int checks = 0, failures = 0;
  bit done = 0;
  logic [15:0] shadow [256];

  always #2 clk = ~clk;

  phase_err_lut i_phase_err_lut (.clk, .rst_n, .i_in, .q_in, .fold_en, .rnd_en,
    .ones_neg, .wr_en, .wr_addr, .wr_data, .err_out);

  function automatic logic [15:0] tword(input int w);
    return 16'((w * 40317 + 23) ^ (w << 5) ^ 16'hC3A5);
  endfunction

  // {i, q, fold, rnd, inv, expected index, expected flip}
  localparam int NV = 10;
  localparam logic [39:0] VEC [NV] = '{
    {12'h000, 12'h000, 1'b0, 1'b0, 1'b0, 12'd0,    1'b0}, // R3 zero
    {12'h7FF, 12'h020, 1'b0, 1'b1, 1'b0, 12'd1984, 1'b0}, // R7 sat, R6 half even stays
    {12'h060, 12'h0A0, 1'b0, 1'b1, 1'b0, 12'd130,  1'b0}, // R6 odd up, even stays
    {12'h060, 12'h0A0, 1'b0, 1'b0, 1'b0, 12'd66,   1'b0}, // R3 truncate
    {12'hFE0, 12'h040, 1'b1, 1'b0, 1'b0, 12'd66,   1'b1}, // R4 twos negation, R8 flip
    {12'hFE0, 12'h040, 1'b1, 1'b0, 1'b1, 12'd2,    1'b1}, // R5 ones negation
    {12'hFF0, 12'hFD0, 1'b1, 1'b1, 1'b0, 12'd2,    1'b1}, // R6 negative halves
    {12'h800, 12'h800, 1'b1, 1'b0, 1'b0, 12'd4095, 1'b0}, // R4 -64 -> 63, R8 both neg
    {12'h7FF, 12'h7F0, 1'b1, 1'b1, 1'b0, 12'd4095, 1'b0}, // R7 folded sat
    {12'hFC0, 12'h040, 1'b0, 1'b0, 1'b0, 12'd4033, 1'b0}  // R8 no flip unfolded
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: err_out=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [8:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    if (a[8]) shadow[a[7:0]] = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic lookup(input logic [11:0] i, input logic [11:0] q,
                        input logic f, input logic r, input logic v);
    @(negedge clk);
    i_in = i; q_in = q; fold_en = f; rnd_en = r; ones_neg = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic predict(input logic [11:0] idx, input logic flip);
    logic [15:0] w;
    w = shadow[idx[11:4]];
    return w[idx[3:0]] ^ flip;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset", err_out, 1'b0);
    rst_n = 1;
    for (int w = 0; w < 256; w++) host_wr(9'(256 + w), tword(w));
    for (int n = 0; n < NV; n++) begin
      lookup(VEC[n][39:28], VEC[n][27:16], VEC[n][15], VEC[n][14], VEC[n][13]);
      chk($sformatf("R1/R3-R8 vector %0d", n), err_out, predict(VEC[n][12:1], VEC[n][0]));
    end
    // R2: low half write ignored; word 0 would otherwise change
    host_wr(9'h000, ~tword(0));
    lookup(12'h000, 12'h000, 0, 0, 0);
    chk("R2 ignored write", err_out, predict(12'd0, 1'b0));
    // R10: new word visible on next lookup
    host_wr(9'h100, 16'h0001);
    lookup(12'h000, 12'h000, 0, 0, 0);
    chk("R10 updated word", err_out, 1'b1);
    // R9 latency: move to entry 1 (bit 1 of word 0 = 0)
    @(negedge clk);
    q_in = 12'h040;
    @(negedge clk);
    chk("R9 latency one edge", err_out, 1'b1);
    @(negedge clk);
    chk("R9 latency two edges", err_out, 1'b0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: done=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule